// File: doc/BRIEF.md
# DDR SDRAM Mode Register Sequencer

This controller-side block writes the two mode-register programming commands a DDR SDRAM expects once its power-up waits are over. A single-cycle `start` pulse, taken while the block is idle, latches the requested burst length, burst ordering and CAS latency. The block then issues a programming command with the DLL-reset bit set. It waits a fixed number of NOP cycles and issues a second programming command that selects normal operation. After another run of NOP cycles it raises `done`.

The operand placed on the low seven address bits is built from the configuration. The upper six bits only ever take one of two legal patterns. A request for a burst length or latency the memory does not support issues no command and raises `err`. The gap length is the parameter `NOP_GAP`. Any value below two is raised to two.

Top module: `mrs_seq`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1) with `ba`=0, `addr`=0, and `busy`, `done` and `err` all 0.
- R2: A `start` sampled on a rising edge while idle with a supported configuration produces, in the next cycle, a programming command (`cs_n`, `ras_n`, `cas_n`, `we_n` all 0) with `ba`=00, `addr[12:7]`=000010 (only A8 set) and `addr[6:0]` carrying the operand.
- R3: Operand fields: `addr[2:0]` is 001, 010 or 011 for `cfg_burst_len` 2, 4 or 8. `addr[3]` equals `cfg_interleave`. `addr[6:4]` is 010 for `cfg_cl_x2`=4 (latency 2) and 110 for `cfg_cl_x2`=5 (latency 2.5).
- R4: The DLL-reset command is followed by exactly max(2,`NOP_GAP`) NOP cycles. Then comes a programming command with `addr[12:7]`=000000, `ba`=00 and the same `addr[6:0]`. No second DLL-reset command comes between them.
- R5: The normal-mode command is followed by exactly max(2,`NOP_GAP`) NOP cycles. In the next cycle `done` is 1 and `busy` is 0. `busy` is 1 from the DLL-reset cycle through the last NOP cycle.
- R6: Every cycle that carries no programming command drives NOP with `ba`=0 and `addr`=0.
- R7: A `start` taken while idle with `cfg_burst_len` not in {2,4,8} or `cfg_cl_x2` not in {4,5} issues no command. `err` is 1 in the next cycle, `busy` stays 0 and `done` goes to 0.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running sequence keeps its timing and its latched operand.
- R9: `err` and `done` hold their values until the next `start` taken while idle. Any such start clears `done`, and a supported one clears `err`.
- R10: A programming command never drives an `addr[12:7]` pattern other than 000000 or 000010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run the programming sequence |
| cfg_burst_len | input | 4 | Requested burst length in beats |
| cfg_interleave | input | 1 | 1 selects interleaved burst order, 0 sequential |
| cfg_cl_x2 | input | 3 | Requested CAS latency times two |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Row address bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Both commands and trailing gap complete |
| err | output | 1 | Last idle start carried an unsupported setting |

## Verification
The bench builds the block with `NOP_GAP`=3, one more than the minimum. A gap counter that is off by one against the parameter, or that ignores it, would stand out. The behavioural model checks every cycle of each sequence against the requirements. This covers the exact positions of both commands and of `done`. Configurations cover all three burst lengths, both latencies and both orders. Unsupported values on each field are also applied, as is a second start inside a running sequence.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;
  localparam int ROW_W = 13;
  localparam int BA_W  = 2;
  localparam int OP_W  = 7;
  localparam int UP_W  = ROW_W - OP_W;

  localparam logic [UP_W-1:0] UPPER_DLL  = 6'b000010;
  localparam logic [UP_W-1:0] UPPER_NORM = 6'b000000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DLL,
    ST_GAP1,
    ST_NORM,
    ST_GAP2
  } seq_state_t;

  // {supported, field[2:0]}
  function automatic logic [3:0] burst_code(input logic [3:0] len);
    case (len)
      4'd2:    burst_code = 4'b1001;
      4'd4:    burst_code = 4'b1010;
      4'd8:    burst_code = 4'b1011;
      default: burst_code = 4'b0000;
    endcase
  endfunction

  // {supported, field[2:0]}, latency given in half clocks
  function automatic logic [3:0] latency_code(input logic [2:0] half_clks);
    case (half_clks)
      3'd4:    latency_code = 4'b1010;
      3'd5:    latency_code = 4'b1110;
      default: latency_code = 4'b0000;
    endcase
  endfunction

  function automatic int eff_gap(input int req);
    eff_gap = (req < 2) ? 2 : req;
  endfunction
endpackage

// File: rtl/mrs_operand.sv
module mrs_operand
  import mrs_seq_pkg::*;
(
  input  logic [3:0]      cfg_burst_len,
  input  logic            cfg_interleave,
  input  logic [2:0]      cfg_cl_x2,
  output logic [OP_W-1:0] op,
  output logic            op_ok
);
  logic [3:0] bl_c;
  logic [3:0] cl_c;

  always_comb begin
    bl_c  = burst_code(cfg_burst_len);
    cl_c  = latency_code(cfg_cl_x2);
    op    = {cl_c[2:0], cfg_interleave, bl_c[2:0]};
    op_ok = bl_c[3] & cl_c[3];
  end
endmodule

// File: rtl/mrs_ctrl.sv
module mrs_ctrl
  import mrs_seq_pkg::*;
#(
  parameter int NOP_GAP = 2
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_ok,
  input  logic [OP_W-1:0] op_in,
  output seq_state_t      state,
  output logic [OP_W-1:0] op_q,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            seq_accept,
  output logic            seq_reject
);
  localparam int GAP_EFF = eff_gap(NOP_GAP);
  localparam int CNT_W   = $clog2(GAP_EFF + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_EFF - 1);

  logic [CNT_W-1:0] cnt;
  logic             idle;

  assign idle       = (state == ST_IDLE);
  assign busy       = ~idle;
  assign seq_accept = idle & start & op_ok;
  assign seq_reject = idle & start & ~op_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      op_q  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            done <= 1'b0;
            if (op_ok) begin
              err   <= 1'b0;
              op_q  <= op_in;
              state <= ST_DLL;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_DLL: begin
          state <= ST_GAP1;
          cnt   <= CNT_LAST;
        end
        ST_GAP1: begin
          if (cnt == '0) state <= ST_NORM;
          else           cnt   <= cnt - 1'b1;
        end
        ST_NORM: begin
          state <= ST_GAP2;
          cnt   <= CNT_LAST;
        end
        ST_GAP2: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mrs_cmd_drive.sv
module mrs_cmd_drive
  import mrs_seq_pkg::*;
(
  input  seq_state_t       state,
  input  logic [OP_W-1:0]  op_q,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [BA_W-1:0]  ba,
  output logic [ROW_W-1:0] addr
);
  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = '0;
    addr  = '0;
    if (state == ST_DLL || state == ST_NORM) begin
      ras_n = 1'b0;
      cas_n = 1'b0;
      we_n  = 1'b0;
      addr  = {(state == ST_DLL) ? UPPER_DLL : UPPER_NORM, op_q};
    end
  end
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_seq_pkg::*;
#(
  parameter int NOP_GAP = 2
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  cfg_burst_len,
  input  logic        cfg_interleave,
  input  logic [2:0]  cfg_cl_x2,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        busy,
  output logic        done,
  output logic        err
);
  logic [OP_W-1:0] op_new;
  logic [OP_W-1:0] op_q;
  logic            op_ok;
  seq_state_t      state;
  logic            seq_accept;
  logic            seq_reject;
  logic            fire_dll;
  logic            fire_norm;

  assign fire_dll  = (state == ST_DLL);
  assign fire_norm = (state == ST_NORM);

  mrs_operand u_operand (
    .cfg_burst_len  (cfg_burst_len),
    .cfg_interleave (cfg_interleave),
    .cfg_cl_x2      (cfg_cl_x2),
    .op             (op_new),
    .op_ok          (op_ok)
  );

  mrs_ctrl #(.NOP_GAP(NOP_GAP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op_ok      (op_ok),
    .op_in      (op_new),
    .state      (state),
    .op_q       (op_q),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .seq_accept (seq_accept),
    .seq_reject (seq_reject)
  );

  mrs_cmd_drive u_drive (
    .state (state),
    .op_q  (op_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr)
  );
endmodule

// File: rtl/mrs_seq_chk.sv
module mrs_seq_chk
  import mrs_seq_pkg::*;
#(
  parameter int NOP_GAP = 2
)(
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        seq_accept,
  input logic        seq_reject,
  input logic        fire_dll
);
  localparam int GAP_EFF = eff_gap(NOP_GAP);

  logic        is_mrs;
  logic        is_nop;
  logic        pend;
  logic [15:0] nop_run;
  logic [6:0]  op_seen;

  assign is_mrs = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_nop = !cs_n && ras_n && cas_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      nop_run <= '0;
      op_seen <= '0;
    end else begin
      if (is_mrs) begin
        nop_run <= '0;
        pend    <= addr[8];
        if (addr[8]) op_seen <= addr[6:0];
      end else if (is_nop && nop_run != 16'hFFFF) begin
        nop_run <= nop_run + 16'd1;
      end
    end
  end

  // R6
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs || (is_nop && addr == '0 && ba == '0));

  // R10
  upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (addr[12:7] == 6'b000010 || addr[12:7] == 6'b000000));

  // R3
  operand_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> ((addr[2:0] == 3'b001 || addr[2:0] == 3'b010 || addr[2:0] == 3'b011)
                && (addr[6:4] == 3'b010 || addr[6:4] == 3'b110)));

  // R2
  accept_to_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept |=> (is_mrs && addr[8] && ba == 2'b00 && busy));

  // R2
  dll_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_dll |-> (is_mrs && addr[8]));

  // R4
  norm_after_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && !addr[8]) |-> (pend && addr[6:0] == op_seen && nop_run == 16'(GAP_EFF)));

  // R4
  no_double_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mrs && addr[8]) |-> !pend);

  // R5
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && is_nop && nop_run == 16'(GAP_EFF)));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_reject |=> (err && !busy && !done && is_nop));
endmodule

bind mrs_seq mrs_seq_chk #(.NOP_GAP(NOP_GAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .ba         (ba),
  .addr       (addr),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .seq_accept (seq_accept),
  .seq_reject (seq_reject),
  .fire_dll   (fire_dll)
);

// File: tb/mrs_seq_tb.sv
module mrs_seq_tb;
  localparam int G = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  cfg_burst_len;
  logic        cfg_interleave;
  logic [2:0]  cfg_cl_x2;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        busy, done, err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model state
  int       ph = -1;
  int       m_op = 0;
  bit       m_done = 0;
  bit       m_err = 0;

  always #10 clk = ~clk;

  mrs_seq #(.NOP_GAP(G)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cl_x2(cfg_cl_x2),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .busy(busy), .done(done), .err(err)
  );

  function automatic int bl_field(input int len);
    if (len == 2) return 1;
    if (len == 4) return 2;
    if (len == 8) return 3;
    return -1;
  endfunction

  function automatic int cl_field(input int x2);
    if (x2 == 4) return 2;
    if (x2 == 5) return 6;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] cmd_bits();
    return 32'({cs_n, ras_n, cas_n, we_n});
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = -1; m_op = 0; m_done = 0; m_err = 0;
    end else if (ph < 0) begin
      if (start) begin
        m_done = 0;
        if (bl_field(int'(cfg_burst_len)) >= 0 && cl_field(int'(cfg_cl_x2)) >= 0) begin
          m_err = 0;
          m_op  = cl_field(int'(cfg_cl_x2)) * 16 + int'(cfg_interleave) * 8
                  + bl_field(int'(cfg_burst_len));
          ph    = 0;
        end else begin
          m_err = 1;
        end
      end
    end else if (ph == 2 * G + 1) begin
      ph = -1;
      m_done = 1;
    end else begin
      ph = ph + 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      string tag;
      bit    cmd;
      int    exp_addr;
      cmd = (ph == 0) || (ph == G + 1);
      exp_addr = 0;
      if (ph == 0)     exp_addr = 256 + m_op;
      if (ph == G + 1) exp_addr = m_op;
      if (ph < 0)            tag = "R6";
      else if (ph == 0)      tag = "R2";
      else if (ph <= G + 1)  tag = "R4";
      else                   tag = "R5";
      chk(tag, cmd_bits(), cmd ? 32'h0 : 32'h7);
      chk(tag, 32'(addr), 32'(exp_addr));
      chk(tag, 32'(ba), 32'h0);
      chk("R5", 32'(busy), 32'(ph >= 0));
      chk("R9", 32'(done), 32'(m_done));
      chk("R7", 32'(err), 32'(m_err));
    end
  end

  task automatic pulse(input int len, input bit il, input int x2);
    @(negedge clk);
    start = 1'b1;
    cfg_burst_len = 4'(len);
    cfg_interleave = il;
    cfg_cl_x2 = 3'(x2);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    cfg_burst_len = 4'd4;
    cfg_interleave = 1'b0;
    cfg_cl_x2 = 3'd4;
    #1;
    // R1 reset state
    chk("R1", cmd_bits(), 32'h7);
    chk("R1", 32'(addr), 32'h0);
    chk("R1", 32'(ba), 32'h0);
    chk("R1", 32'({busy, done, err}), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", 32'({busy, done, err}), 32'h0);

    // burst 4, sequential, latency 2
    pulse(4, 1'b0, 4);
    chk("R2", cmd_bits(), 32'h0);
    chk("R3", 32'(addr), 32'({6'b000010, 3'b010, 1'b0, 3'b010}));
    repeat (G + 1) @(negedge clk);
    chk("R4", 32'(addr), 32'({6'b000000, 3'b010, 1'b0, 3'b010}));
    chk("R10", 32'(addr[12:7]), 32'h0);
    repeat (G) @(negedge clk);
    chk("R5", 32'({busy, done}), 32'b10);
    @(negedge clk);
    chk("R5", 32'({busy, done}), 32'b01);

    // burst 8, interleaved, latency 2.5, with an ignored start mid-sequence
    pulse(8, 1'b1, 5);
    chk("R3", 32'(addr), 32'({6'b000010, 3'b110, 1'b1, 3'b011}));
    chk("R9", 32'(done), 32'h0);
    pulse(2, 1'b0, 4);
    repeat (G - 1) @(negedge clk);
    chk("R8", 32'(addr), 32'({6'b000000, 3'b110, 1'b1, 3'b011}));
    chk("R8", cmd_bits(), 32'h0);
    repeat (G + 1) @(negedge clk);
    chk("R8", 32'({busy, done}), 32'b01);

    // burst 2, sequential, latency 2
    pulse(2, 1'b0, 4);
    chk("R3", 32'(addr), 32'({6'b000010, 3'b010, 1'b0, 3'b001}));
    repeat (2 * G + 3) @(negedge clk);

    // unsupported burst length
    pulse(3, 1'b0, 4);
    chk("R7", 32'({err, busy, done}), 32'b100);
    chk("R7", cmd_bits(), 32'h7);
    repeat (3) @(negedge clk);
    chk("R9", 32'(err), 32'h1);
    // unsupported latency
    pulse(4, 1'b0, 6);
    chk("R7", 32'({err, busy}), 32'b10);
    // zero burst length
    pulse(0, 1'b1, 5);
    chk("R7", 32'({err, busy}), 32'b10);
    chk("R7", 32'(addr), 32'h0);
    // supported start clears the error
    pulse(8, 1'b0, 4);
    chk("R9", 32'(err), 32'h0);
    chk("R2", cmd_bits(), 32'h0);
    repeat (2 * G + 2) @(negedge clk);
    chk("R5", 32'(done), 32'h1);
    repeat (4) @(negedge clk);
    chk("R9", 32'({done, err}), 32'b10);

    summary();
  end
endmodule